// File: doc/BRIEF.md
# Serial Transmit Holding Register Controller

This block is the transmit side of one serial channel, built as a double buffer. The host puts a character into a one-entry holding register. A separate shift register sends the character on the serial line. The character moves from the holding register into the shifter on the first baud tick at which the shifter has nothing to send. While that frame is on the line, the host can load the next character. A registered ready flag tells the host when the holding register can take a new character.

An enable input gates the transmitter. On the clock edge that sees the enable rise, the ready flag goes high. While the enable is low, the ready flag stays low, the holding register is emptied, and host writes are dropped rather than kept for later. A frame already in the shifter when the enable falls still runs to its stop bit. Baud timing comes from a one-cycle tick input. Each frame is one low start bit, the data bits with the least significant bit first, and one high stop bit.

Top module: `txhold_ctrl`

## Requirements
- R1: During and after a synchronous active-low reset with the enable low, `ready_o` is 0 and `txd_o` is 1.
- R2: When `tx_enable_i` is sampled high one cycle after it was sampled low, `ready_o` is 1 after that clock edge, unless a write is accepted in the same cycle.
- R3: A write (`wr_en_i` high while `tx_enable_i` is high) captures `wr_data_i` into the holding register and drives `ready_o` to 0 after that clock edge.
- R4: A held character moves into the shifter only on a clock edge where `baud_tick_i` is 1 and the shifter is idle. At that edge `ready_o` becomes 1, unless a write happens in the same cycle. With no tick, the character waits and the line stays high.
- R5: After the load edge, `txd_o` shows the start bit (0). Each later tick moves the line to the next bit: data bit 0 through bit DATA_W-1, then the stop bit (1). The next tick returns the shifter to idle. The line is 1 whenever the shifter is idle.
- R6: While `tx_enable_i` is low, `ready_o` is 0 after each clock edge. A write made while disabled is discarded: after re-enabling, `ready_o` is 1 and no frame is sent on later ticks.
- R7: Dropping `tx_enable_i` during a frame lets that frame finish unchanged. A character waiting in the holding register at that time is dropped and never sent.
- R8: If a write and a transfer fall in the same cycle, the old held character goes into the shifter and the new one is captured. `ready_o` stays 0, and the new character is sent as the next frame.
- R9: A second write while the holding register is still full replaces the held character. Only the last character written is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe for the holding register |
| wr_data_i | input | DATA_W | Character written by the host |
| tx_enable_i | input | 1 | Transmitter enable level |
| baud_tick_i | input | 1 | One-cycle pulse marking a bit period boundary |
| txd_o | output | 1 | Serial line, idles high |
| ready_o | output | 1 | Holding register can accept a character |

## Verification
A host write and a holding-to-shifter transfer can land on the same clock edge. The transfer tries to set the ready flag and the write tries to clear it. The bench provokes this by leaving a character held while the shifter is idle, then driving the write strobe and the baud tick in the same cycle. It judges the result in three ways: the start bit of the old character appears at once, the ready flag stays low, and after that frame finishes, the next tick sends the new character bit for bit. The disable-during-frame and disabled-write scenarios are judged only at the line and ready pins, over enough ticks that a wrongly kept character would show up.

// File: rtl/txh_pkg.sv
// Package txh_pkg
// Shared framing constants and the shifter state type for the transmit
// holding register controller. Assumes a single start and single stop bit.
package txh_pkg;
    localparam int START_BITS = 1;
    localparam int STOP_BITS  = 1;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_BUSY = 1'b1
    } sh_state_e;
endpackage

// File: rtl/txh_enable_track.sv
// Module txh_enable_track
// Registers the transmitter enable level and flags the first cycle in which
// it is seen high after being low. Assumes tx enable is synchronous to clk.
module txh_enable_track (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic en_rise_o
);
    logic en_q;

    // Remember last cycle's enable level.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_i;
    end

    assign en_rise_o = en_i & ~en_q;
endmodule

// File: rtl/txh_holding.sv
// Module txh_holding
// One-entry holding register with its ready flag. Takes host writes while
// enabled, drops them while disabled, and hands the character to the shifter
// on a baud tick when the shifter is idle. Assumes wr_i is a one-cycle strobe
// per character.
module txh_holding #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              en_rise_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              tick_i,
    input  logic              sh_idle_i,
    output logic              load_o,
    output logic [DATA_W-1:0] data_o,
    output logic              ready_o
);
    logic [DATA_W-1:0] data_q;
    logic              valid_q;
    logic              ready_q;

    // Transfer request: enabled, tick present, shifter free, character held.
    assign load_o = en_i & tick_i & sh_idle_i & valid_q;

    // Holding register state; priority is disable, write, transfer, enable edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
            ready_q <= 1'b0;
        end else if (!en_i) begin
            valid_q <= 1'b0;
            ready_q <= 1'b0;
        end else if (wr_i) begin
            data_q  <= wr_data_i;
            valid_q <= 1'b1;
            ready_q <= 1'b0;
        end else if (load_o) begin
            valid_q <= 1'b0;
            ready_q <= 1'b1;
        end else if (en_rise_i) begin
            ready_q <= 1'b1;
        end
    end

    assign data_o  = data_q;
    assign ready_o = ready_q;

    assert_ready_low_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !ready_q);
    assert_ready_on_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rise_i && !wr_i) |=> ready_q);
    assert_write_clears_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && wr_i) |=> (!ready_q && valid_q));
    assert_transfer_sets_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o && !wr_i) |=> (ready_q && !valid_q));
    assert_collision_holds_new_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o && wr_i) |=> (!ready_q && valid_q));
endmodule

// File: rtl/txh_shifter.sv
// Module txh_shifter
// Frame serialiser: start bit, DATA_W data bits LSB first, stop bit, one bit
// per baud tick. A frame, once loaded, always runs to completion. Assumes
// load_i is only raised while idle_o is high.
module txh_shifter
    import txh_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              idle_o,
    output logic              txd_o
);
    localparam int FRAME_W = START_BITS + DATA_W + STOP_BITS;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    sh_state_e          state_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   cnt_q;

    // Load a framed character, then shift one bit per tick until done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SH_IDLE;
            shreg_q <= '1;
            cnt_q   <= '0;
        end else if (state_q == SH_IDLE) begin
            if (load_i) begin
                shreg_q <= {{STOP_BITS{1'b1}}, data_i, {START_BITS{1'b0}}};
                cnt_q   <= CNT_W'(FRAME_W);
                state_q <= SH_BUSY;
            end
        end else if (tick_i) begin
            if (cnt_q == CNT_W'(1)) begin
                state_q <= SH_IDLE;
                shreg_q <= '1;
                cnt_q   <= '0;
            end else begin
                shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
                cnt_q   <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign idle_o = (state_q == SH_IDLE);
    assign txd_o  = shreg_q[0];

    assert_idle_line_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_IDLE) |-> txd_o);
    assert_start_bit_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && state_q == SH_IDLE) |=> !txd_o);
    assert_count_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(FRAME_W));
    assert_hold_without_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_BUSY && !tick_i) |=> $stable(shreg_q));
endmodule

// File: rtl/txhold_ctrl.sv
// Module txhold_ctrl
// Top of the transmit holding register controller: joins the enable
// tracker, the holding register and the frame shifter. Assumes baud_tick_i
// is a single-cycle pulse and all inputs are synchronous to clk.
module txhold_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              tx_enable_i,
    input  logic              baud_tick_i,
    output logic              txd_o,
    output logic              ready_o
);
    logic              en_rise;
    logic              sh_idle;
    logic              load;
    logic [DATA_W-1:0] hold_data;

    txh_enable_track u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (tx_enable_i),
        .en_rise_o (en_rise)
    );

    txh_holding #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (tx_enable_i),
        .en_rise_i (en_rise),
        .wr_i      (wr_en_i),
        .wr_data_i (wr_data_i),
        .tick_i    (baud_tick_i),
        .sh_idle_i (sh_idle),
        .load_o    (load),
        .data_o    (hold_data),
        .ready_o   (ready_o)
    );

    txh_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (baud_tick_i),
        .load_i (load),
        .data_i (hold_data),
        .idle_o (sh_idle),
        .txd_o  (txd_o)
    );

    assert_load_needs_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (sh_idle && baud_tick_i));
endmodule

// File: tb/txhold_ctrl_tb.sv
`timescale 1ns/1ps
module txhold_ctrl_tb;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              tx_en = 1'b0;
    logic              tick = 1'b0;
    logic              txd;
    logic              ready;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    txhold_ctrl #(.DATA_W(DATA_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .tx_enable_i (tx_en),
        .baud_tick_i (tick),
        .txd_o       (txd),
        .ready_o     (ready)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One clock with the given tick and write; ends at the next falling edge.
    task automatic step(input logic t, input logic w, input logic [DATA_W-1:0] d);
        @(negedge clk);
        tick = t; wr_en = w; wr_data = d;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
    endtask

    task automatic set_enable(input logic e);
        @(negedge clk);
        tx_en = e;
        @(negedge clk);
    endtask

    // After the load edge: check data bits, stop bit and idle tick.
    task automatic run_frame(input string req, input logic [DATA_W-1:0] b);
        for (int i = 0; i < DATA_W; i++) begin
            step(1'b1, 1'b0, '0);
            check(req, txd, b[i]);
        end
        step(1'b1, 1'b0, '0);
        check(req, txd, 1'b1);
        step(1'b1, 1'b0, '0);
        check(req, txd, 1'b1);
    endtask

    task automatic quiet_ticks(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b0, '0);
            check(req, txd, 1'b1);
        end
    endtask

    task automatic t_reset;
        check("R1", ready, 1'b0);
        check("R1", txd, 1'b1);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1", ready, 1'b0);
        check("R1", txd, 1'b1);
    endtask

    task automatic t_enable;
        set_enable(1'b1);
        check("R2", ready, 1'b1);
    endtask

    task automatic t_basic;
        step(1'b0, 1'b1, 8'hA5);
        check("R3", ready, 1'b0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R4", txd, 1'b1);
            check("R4", ready, 1'b0);
        end
        step(1'b1, 1'b0, '0);
        check("R4", ready, 1'b1);
        check("R5", txd, 1'b0);
        run_frame("R5", 8'hA5);
    endtask

    task automatic t_disabled_write;
        set_enable(1'b0);
        check("R6", ready, 1'b0);
        step(1'b0, 1'b1, 8'h3C);
        check("R6", ready, 1'b0);
        set_enable(1'b1);
        check("R6", ready, 1'b1);
        quiet_ticks("R6", 12);
        check("R6", ready, 1'b1);
    endtask

    task automatic t_disable_midframe;
        step(1'b0, 1'b1, 8'h5A);
        step(1'b1, 1'b0, '0);
        check("R7", txd, 1'b0);
        step(1'b0, 1'b1, 8'hC3);
        check("R7", ready, 1'b0);
        set_enable(1'b0);
        run_frame("R7", 8'h5A);
        set_enable(1'b1);
        check("R7", ready, 1'b1);
        quiet_ticks("R7", 12);
    endtask

    task automatic t_collision;
        step(1'b0, 1'b1, 8'h96);
        step(1'b1, 1'b1, 8'h4E);
        check("R8", txd, 1'b0);
        check("R8", ready, 1'b0);
        run_frame("R8", 8'h96);
        check("R8", ready, 1'b0);
        step(1'b1, 1'b0, '0);
        check("R8", txd, 1'b0);
        check("R8", ready, 1'b1);
        run_frame("R8", 8'h4E);
    endtask

    task automatic t_overwrite;
        step(1'b0, 1'b1, 8'h11);
        step(1'b0, 1'b1, 8'hE2);
        check("R9", ready, 1'b0);
        step(1'b1, 1'b0, '0);
        check("R9", txd, 1'b0);
        run_frame("R9", 8'hE2);
        quiet_ticks("R9", 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        t_enable;
        t_basic;
        t_disabled_write;
        t_disable_midframe;
        t_collision;
        t_overwrite;
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule